// File: doc/BRIEF.md
# PCM Serial Port with Frame-Sync Width Detection

This block is the serial side of a voice codec channel. Once per transmit frame it shifts one 8-bit encoded sample out on a tri-stated data line. Once per receive frame it captures one 8-bit sample from the serial input and presents it as a parallel word with a one-cycle valid strobe. The bit clocks and frame syncs are sampled in the block's own system clock domain. That domain must run several times faster than the bit clocks, so every bit-clock edge is seen as a one-cycle event. Each output change follows the bit-clock or sync edge that causes it by one system clock.

Two framing conventions are supported. A one-bit-wide sync marks the bit period just before the first data bit. A sync three or more bit periods wide frames the data directly. The block does not need to be told which one is in use. It measures the width of each transmit sync pulse in falling bit-clock edges and keeps the detected convention for later frames. Both directions use that convention. When the transmitter arms or the receiver starts a capture, the convention in force is latched, so a change of mode in the middle of a frame does not affect that frame.

The transmit word is double-buffered. Each frame start moves the held word into the shifter and samples the parallel input into the holding register. As a result, every frame sends the word presented at the previous frame start, which is the output of the previous encode cycle.

Top module: `pcm_serial_port`

## Requirements
- R1: After reset the data enable `tx_oe_o` is 0, `rx_valid_o` is 0, and the detected convention is the one-bit-wide (short) sync.
- R2: Short mode transmit. A falling bit-clock edge that samples `tx_fsync_i` high arms the frame, and `tx_oe_o` stays 0 at that point. The next rising edge sets `tx_oe_o` to 1 and drives bit 7. Each of the following seven rising edges drives the next lower bit. The falling edge after the eighth rising edge clears `tx_oe_o`. While `tx_oe_o` is 0, `tx_sdata_o` does not change.
- R3: Short mode receive. A falling edge that samples `rx_fsync_i` high arms capture. The eight falling edges that follow each sample `rx_sdata_i`, first into bit 7 and last into bit 0.
- R4: The width of a transmit sync pulse is the number of falling `tx_bclk_i` edges that sample it high. The width is judged at the first falling edge that samples it low. A width of 1 selects short mode, a width of LONG_MIN (default 3) or more selects long mode, and a width of 2 leaves the mode as it was.
- R5: Long mode transmit enable. After a rising edge of `tx_fsync_i`, `tx_oe_o` goes to 1 and bit 7 is driven at whichever comes later: the sync rise or the bit-clock rise. If the sync rises while the bit clock is already high, the output is enabled at once.
- R6: Long mode transmit disable. Bits 6 down to 0 follow on the next seven rising edges. `tx_oe_o` goes to 0 at whichever comes later: the falling edge after the eighth rising edge, or the sync going low.
- R7: Long mode receive. After a rising edge of `rx_fsync_i`, the next eight falling `rx_bclk_i` edges capture bits 7 down to 0.
- R8: Each frame start samples `tx_word_i` into a holding register, and the frame transmits the word held from the previous frame start. The first frame after reset transmits IDLE_WORD (default 8'hD5).
- R9: One system clock after the eighth capture edge, `rx_word_o` takes the received word and `rx_valid_o` is 1 for exactly one cycle. `rx_word_o` then holds until the next completed capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clocks |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_bclk_i | input | 1 | Transmit bit clock |
| tx_fsync_i | input | 1 | Transmit frame sync; its width selects the mode |
| tx_word_i | input | WORD_W | Encoded word for the following frame |
| rx_bclk_i | input | 1 | Receive bit clock |
| rx_fsync_i | input | 1 | Receive frame sync |
| rx_sdata_i | input | 1 | Serial receive data |
| tx_sdata_o | output | 1 | Serial transmit data |
| tx_oe_o | output | 1 | Tri-state enable for tx_sdata_o |
| rx_word_o | output | WORD_W | Last received word |
| rx_valid_o | output | 1 | One-cycle strobe for a new rx_word_o |

## Verification
Several properties are checked on every cycle. The enable only rises while the bit clock is high. It only falls on a falling edge or with the sync low. The serial output stays quiet while it is disabled. The mode only changes on a falling edge that samples the sync low. On the receive side, the valid strobe lasts one cycle and comes just after a falling edge, and the received word holds between strobes.

Other behaviour can only be shown by the directed scenarios. These cover bit order and values, the one-frame delay of the transmit word, and the idle word in the first frame. They also cover the choice of the later event for enable and disable in long mode, and the handling of a width-2 pulse, which keeps the mode, against a width-1 pulse, which returns it to short.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

    typedef enum logic {
        FSYNC_SHORT = 1'b0,
        FSYNC_LONG  = 1'b1
    } fsync_mode_e;

    typedef enum logic [1:0] {
        TXS_IDLE  = 2'd0,
        TXS_ARMED = 2'd1,
        TXS_SHIFT = 2'd2,
        TXS_HOLD  = 2'd3
    } tx_state_e;

    typedef enum logic {
        RXS_IDLE    = 1'b0,
        RXS_CAPTURE = 1'b1
    } rx_state_e;

endpackage

// File: rtl/pcm_edge_det.sv
module pcm_edge_det #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig_i,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);

    typedef struct packed {
        logic [N-1:0] lvl;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.lvl = sig_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_edge
        assign rise_o[g] = sig_i[g] & ~st_q.lvl[g];
        assign fall_o[g] = ~sig_i[g] & st_q.lvl[g];
    end

endmodule

// File: rtl/pcm_width_det.sv
module pcm_width_det
    import pcm_port_pkg::*;
#(
    parameter int CNT_W    = 3,
    parameter int LONG_MIN = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fall_i,
    input  logic        sync_i,
    output fsync_mode_e mode_o
);

    localparam logic [CNT_W-1:0] ONE_C      = CNT_W'(1);
    localparam logic [CNT_W-1:0] LONG_MIN_C = CNT_W'(LONG_MIN);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        fsync_mode_e      mode;
    } width_st_t;

    width_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fall_i) begin
            if (sync_i) begin
                if (st_q.cnt != '1) begin
                    st_d.cnt = st_q.cnt + ONE_C;
                end
            end else if (st_q.cnt != '0) begin
                if (st_q.cnt == ONE_C) begin
                    st_d.mode = FSYNC_SHORT;
                end else if (st_q.cnt >= LONG_MIN_C) begin
                    st_d.mode = FSYNC_LONG;
                end
                st_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.mode <= FSYNC_SHORT;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o = st_q.mode;

    AST_MODE_ON_SYNC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode != $past(st_q.mode)) |-> ($past(fall_i) && !$past(sync_i))); // R4

endmodule

// File: rtl/pcm_tx_shifter.sv
module pcm_tx_shifter
    import pcm_port_pkg::*;
#(
    parameter int                WORD_W    = 8,
    parameter logic [WORD_W-1:0] IDLE_WORD = 8'hD5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              sync_i,
    input  logic              sync_rise_i,
    input  fsync_mode_e       mode_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              sdata_o,
    output logic              oe_o
);

    localparam int               CNT_W  = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

    typedef struct packed {
        tx_state_e         state;
        fsync_mode_e       fmode;
        logic [WORD_W-1:0] hold;
        logic [WORD_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic              oe;
        logic              sdata;
    } tx_st_t;

    tx_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.state)
            TXS_IDLE: begin
                if (mode_i == FSYNC_SHORT && fall_i && sync_i) begin
                    st_d.state = TXS_ARMED;
                    st_d.fmode = FSYNC_SHORT;
                    st_d.shreg = st_q.hold;
                    st_d.hold  = word_i;
                end else if (mode_i == FSYNC_LONG && sync_rise_i) begin
                    st_d.fmode = FSYNC_LONG;
                    st_d.hold  = word_i;
                    if (bclk_i) begin
                        st_d.state = TXS_SHIFT;
                        st_d.oe    = 1'b1;
                        st_d.sdata = st_q.hold[WORD_W-1];
                        st_d.shreg = st_q.hold << 1;
                        st_d.cnt   = '0;
                    end else begin
                        st_d.state = TXS_ARMED;
                        st_d.shreg = st_q.hold;
                    end
                end
            end
            TXS_ARMED: begin
                if (st_q.fmode == FSYNC_LONG && !sync_i) begin
                    st_d.state = TXS_IDLE;
                end else if (rise_i) begin
                    st_d.state = TXS_SHIFT;
                    st_d.oe    = 1'b1;
                    st_d.sdata = st_q.shreg[WORD_W-1];
                    st_d.shreg = st_q.shreg << 1;
                    st_d.cnt   = '0;
                end
            end
            TXS_SHIFT: begin
                if (rise_i && st_q.cnt != LAST_C) begin
                    st_d.sdata = st_q.shreg[WORD_W-1];
                    st_d.shreg = st_q.shreg << 1;
                    st_d.cnt   = st_q.cnt + ONE_C;
                end else if (fall_i && st_q.cnt == LAST_C) begin
                    if (st_q.fmode == FSYNC_SHORT) begin
                        st_d.oe = 1'b0;
                        if (mode_i == FSYNC_SHORT && sync_i) begin
                            st_d.state = TXS_ARMED;
                            st_d.shreg = st_q.hold;
                            st_d.hold  = word_i;
                        end else begin
                            st_d.state = TXS_IDLE;
                        end
                    end else if (!sync_i) begin
                        st_d.oe    = 1'b0;
                        st_d.state = TXS_IDLE;
                    end else begin
                        st_d.state = TXS_HOLD;
                    end
                end
            end
            TXS_HOLD: begin
                if (!sync_i) begin
                    st_d.oe    = 1'b0;
                    st_d.state = TXS_IDLE;
                end
            end
            default: st_d.state = TXS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.state <= TXS_IDLE;
            st_q.fmode <= FSYNC_SHORT;
            st_q.hold  <= IDLE_WORD;
            st_q.shreg <= '0;
            st_q.cnt   <= '0;
            st_q.oe    <= 1'b0;
            st_q.sdata <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdata_o = st_q.sdata;
    assign oe_o    = st_q.oe;

    AST_OE_RISE_BCLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.oe) |-> $past(bclk_i)); // R5

    AST_OE_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.oe) |-> ($past(fall_i) || !$past(sync_i))); // R6

    AST_SDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.oe |-> $stable(st_q.sdata)); // R2

endmodule

// File: rtl/pcm_rx_shifter.sv
module pcm_rx_shifter
    import pcm_port_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_i,
    input  logic              sync_i,
    input  logic              sync_rise_i,
    input  logic              sdata_i,
    input  fsync_mode_e       mode_i,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o
);

    localparam int               CNT_W  = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

    typedef struct packed {
        rx_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] shreg;
        logic [WORD_W-1:0] word;
        logic              valid;
    } rx_st_t;

    rx_st_t st_d, st_q;
    logic   short_arm, long_arm;
    logic [WORD_W-1:0] shifted;

    assign short_arm = (mode_i == FSYNC_SHORT) && fall_i && sync_i;
    assign long_arm  = (mode_i == FSYNC_LONG) && sync_rise_i;
    assign shifted   = {st_q.shreg[WORD_W-2:0], sdata_i};

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        unique case (st_q.state)
            RXS_IDLE: begin
                if (short_arm || long_arm) begin
                    st_d.state = RXS_CAPTURE;
                    st_d.cnt   = '0;
                end
            end
            RXS_CAPTURE: begin
                if (fall_i) begin
                    st_d.shreg = shifted;
                    if (st_q.cnt == LAST_C) begin
                        st_d.word  = shifted;
                        st_d.valid = 1'b1;
                        st_d.cnt   = '0;
                        st_d.state = short_arm ? RXS_CAPTURE : RXS_IDLE;
                    end else begin
                        st_d.cnt = st_q.cnt + ONE_C;
                    end
                end
            end
            default: st_d.state = RXS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.state <= RXS_IDLE;
            st_q.cnt   <= '0;
            st_q.shreg <= '0;
            st_q.word  <= '0;
            st_q.valid <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o  = st_q.word;
    assign valid_o = st_q.valid;

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |=> !st_q.valid); // R9

    AST_VALID_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |-> $past(fall_i)); // R7

    AST_WORD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.valid |-> $stable(st_q.word)); // R9

endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port
    import pcm_port_pkg::*;
#(
    parameter int                WORD_W    = 8,
    parameter logic [WORD_W-1:0] IDLE_WORD = 8'hD5,
    parameter int                WIDTH_CNT = 3,
    parameter int                LONG_MIN  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_bclk_i,
    input  logic              tx_fsync_i,
    input  logic [WORD_W-1:0] tx_word_i,
    input  logic              rx_bclk_i,
    input  logic              rx_fsync_i,
    input  logic              rx_sdata_i,
    output logic              tx_sdata_o,
    output logic              tx_oe_o,
    output logic [WORD_W-1:0] rx_word_o,
    output logic              rx_valid_o
);

    localparam int N_EDGE  = 4;
    localparam int IX_TXCK = 0;
    localparam int IX_TXFS = 1;
    localparam int IX_RXCK = 2;
    localparam int IX_RXFS = 3;

    logic [N_EDGE-1:0] raw_sig, rise, fall;
    fsync_mode_e       mode;

    assign raw_sig[IX_TXCK] = tx_bclk_i;
    assign raw_sig[IX_TXFS] = tx_fsync_i;
    assign raw_sig[IX_RXCK] = rx_bclk_i;
    assign raw_sig[IX_RXFS] = rx_fsync_i;

    pcm_edge_det #(.N(N_EDGE)) u_edges (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (raw_sig),
        .rise_o (rise),
        .fall_o (fall)
    );

    pcm_width_det #(.CNT_W(WIDTH_CNT), .LONG_MIN(LONG_MIN)) u_width (
        .clk    (clk),
        .rst_n  (rst_n),
        .fall_i (fall[IX_TXCK]),
        .sync_i (tx_fsync_i),
        .mode_o (mode)
    );

    pcm_tx_shifter #(.WORD_W(WORD_W), .IDLE_WORD(IDLE_WORD)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .bclk_i      (tx_bclk_i),
        .rise_i      (rise[IX_TXCK]),
        .fall_i      (fall[IX_TXCK]),
        .sync_i      (tx_fsync_i),
        .sync_rise_i (rise[IX_TXFS]),
        .mode_i      (mode),
        .word_i      (tx_word_i),
        .sdata_o     (tx_sdata_o),
        .oe_o        (tx_oe_o)
    );

    pcm_rx_shifter #(.WORD_W(WORD_W)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .fall_i      (fall[IX_RXCK]),
        .sync_i      (rx_fsync_i),
        .sync_rise_i (rise[IX_RXFS]),
        .sdata_i     (rx_sdata_i),
        .mode_i      (mode),
        .word_o      (rx_word_o),
        .valid_o     (rx_valid_o)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!tx_oe_o && !rx_valid_o)); // R1

endmodule

// File: tb/pcm_serial_port_bench.sv
module pcm_serial_port_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bclk = 1'b0;
    logic       fsync = 1'b0;
    logic [7:0] tx_word = 8'h00;
    logic       rx_sdata = 1'b0;
    logic       tx_sdata, tx_oe, rx_valid;
    logic [7:0] rx_word;

    int         checks = 0;
    int         errors = 0;
    int         vcount = 0;
    logic [7:0] last_rx = 8'h00;
    logic       prev_valid = 1'b0;
    logic       dbl = 1'b0;
    logic [7:0] held = 8'hD5;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pcm_serial_port u_pcm_serial_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_bclk_i  (bclk),
        .tx_fsync_i (fsync),
        .tx_word_i  (tx_word),
        .rx_bclk_i  (bclk),
        .rx_fsync_i (fsync),
        .rx_sdata_i (rx_sdata),
        .tx_sdata_o (tx_sdata),
        .tx_oe_o    (tx_oe),
        .rx_word_o  (rx_word),
        .rx_valid_o (rx_valid)
    );

    always @(negedge clk) begin
        if (rx_valid) begin
            vcount  = vcount + 1;
            last_rx = rx_word;
            if (prev_valid) dbl = 1'b1;
        end
        prev_valid = rx_valid;
    end

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic half(input logic v);
        @(negedge clk);
        bclk = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic rx_checks(input int vc0, input logic [7:0] rxb);
        chk(vcount == vc0 + 1 && !dbl, "R9 single valid pulse per frame", vcount - vc0, 1);
        chk(last_rx == rxb, "R3/R7 captured word", last_rx, rxb);
        repeat (4) @(negedge clk);
        chk(rx_word == rxb && !rx_valid, "R9 word holds after strobe", rx_word, rxb);
    endtask

    // Short mode frame; sync_falls = falling edges that see the sync high
    task automatic short_frame(input logic [7:0] txb, input logic [7:0] rxb, input int sync_falls);
        logic [7:0] exp, got;
        int vc0;
        exp = held; held = txb; vc0 = vcount; got = '0;
        @(negedge clk);
        tx_word = txb;
        fsync = 1'b1;
        half(1'b1);
        half(1'b0);
        chk(tx_oe == 1'b0, "R2 enable stays low at arming fall", tx_oe, 0);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            fsync = (i + 1 < sync_falls);
            rx_sdata = rxb[7-i];
            half(1'b1);
            chk(tx_oe == 1'b1 && tx_sdata == exp[7-i], "R2 bit driven on rise",
                {tx_oe, tx_sdata}, {1'b1, exp[7-i]});
            got[7-i] = tx_sdata;
            half(1'b0);
        end
        chk(tx_oe == 1'b0, "R2 enable cleared at fall after eighth rise", tx_oe, 0);
        chk(got == exp, "R8 word from previous frame start", got, exp);
        rx_checks(vc0, rxb);
    endtask

    // Long mode frame; drop_after = falling edges that see the sync high
    task automatic long_frame(input logic [7:0] txb, input logic [7:0] rxb,
                              input bit rise_in_high, input int drop_after);
        logic [7:0] exp, got;
        int vc0;
        exp = held; held = txb; vc0 = vcount; got = '0;
        @(negedge clk);
        tx_word = txb;
        rx_sdata = rxb[7];
        if (!rise_in_high) begin
            @(negedge clk);
            fsync = 1'b1;
            repeat (2) @(negedge clk);
            chk(tx_oe == 1'b0, "R5 enable waits for bit clock rise", tx_oe, 0);
            half(1'b1);
        end else begin
            @(negedge clk);
            bclk = 1'b1;
            repeat (2) @(negedge clk);
            chk(tx_oe == 1'b0, "R5 enable waits for sync rise", tx_oe, 0);
            fsync = 1'b1;
            repeat (2) @(negedge clk);
        end
        chk(tx_oe == 1'b1 && tx_sdata == exp[7], "R5 enable at later edge with bit 7",
            {tx_oe, tx_sdata}, {1'b1, exp[7]});
        got[7] = tx_sdata;
        half(1'b0);
        for (int i = 1; i < 8; i++) begin
            @(negedge clk);
            fsync = (i < drop_after);
            rx_sdata = rxb[7-i];
            half(1'b1);
            chk(tx_oe == 1'b1 && tx_sdata == exp[7-i], "R6 long mode bit on rise",
                {tx_oe, tx_sdata}, {1'b1, exp[7-i]});
            got[7-i] = tx_sdata;
            half(1'b0);
        end
        if (drop_after <= 7) begin
            chk(tx_oe == 1'b0, "R6 disable at fall after eighth rise", tx_oe, 0);
        end else begin
            chk(tx_oe == 1'b1, "R6 enable held while sync high", tx_oe, 1);
            for (int k = 8; k < drop_after; k++) begin
                half(1'b1);
                half(1'b0);
            end
            chk(tx_oe == 1'b1, "R6 enable still held", tx_oe, 1);
            @(negedge clk);
            fsync = 1'b0;
            repeat (2) @(negedge clk);
            chk(tx_oe == 1'b0, "R6 disable at sync fall", tx_oe, 0);
        end
        chk(got == exp, "R8 word from previous frame start", got, exp);
        rx_checks(vc0, rxb);
    endtask

    initial begin : main
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_oe == 1'b0 && rx_valid == 1'b0, "R1 reset state", {tx_oe, rx_valid}, 0);
        // R1 R8: first frame is short and sends the idle word
        short_frame(8'hA1, 8'h5A, 1);
        short_frame(8'h3C, 8'hC3, 1);
        // R4: a width-3 pulse switches to long mode after this frame
        short_frame(8'hE7, 8'h81, 3);
        // R5 R7: sync rises while bit clock low
        long_frame(8'h0F, 8'hF0, 1'b0, 3);
        // R5 R6: sync rises while bit clock high, held past the eighth fall
        long_frame(8'h96, 8'h69, 1'b1, 10);
        // R4: width 2 keeps long mode
        long_frame(8'h55, 8'hAA, 1'b0, 2);
        // R4: long mode still active (enable at sync rise), width 1 returns to short
        long_frame(8'h12, 8'h34, 1'b1, 1);
        short_frame(8'h77, 8'h88, 1);
        repeat (10) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule